// File: doc/BRIEF.md
# Peripheral Clock Routing Register Bank

This block keeps one routing record for each peripheral clock channel. A record holds a generator number (which generic clock generator feeds the channel), a channel enable and a write-protect bit. Software reaches every record through one 16-bit control word that carries a channel number. A full write updates the addressed record. A write that carries only the channel number moves the read pointer, so that record's contents appear on the read port.

Two synchronous reset inputs act on the records. The power-on reset puts every record into its default state. The user reset is gentler and follows a rule per channel: protected records survive it, the real-time-clock record also survives while it is running, and the watchdog record reloads defaults from two nonvolatile configuration inputs. Clock generation and clock gating are handled outside this block.

Top module: `clk_route_bank`

## Requirements
- R1: Channels 0 to 37 are implemented. A write to any channel number from 38 to 63 has no effect, and reading such a channel returns that channel number with generator, enable and protect all zero.
- R2: When power-on reset is applied, every record except the watchdog record (channel 3) gets generator 0, enable 0 and protect 0. This includes the real-time-clock record (channel 4).
- R3: When power-on reset is applied, the watchdog record gets generator 2, its enable takes the value of nv_wdt_en and its protect bit takes the value of nv_wdt_aon.
- R4: A user reset never changes the protect bit of any record.
- R5: On user reset, an ordinary record with protect 0 gets generator 0 and enable 0. An ordinary record with protect 1 keeps all of its fields.
- R6: On user reset, the real-time-clock record gets generator 0 and enable 0 only when its protect bit and its enable are both 0. Otherwise it keeps its values.
- R7: On user reset, the watchdog record with protect 0 reloads generator 2 and reloads its enable from nv_wdt_en. With protect 1 it keeps its values.
- R8: Control word layout: channel number in bits [5:0], generator in bits [11:8], enable in bit 14, protect in bit 15. An accepted word with wr_full=1 writes these fields into the addressed record. An accepted word with wr_full=0 changes no record and only moves the read pointer.
- R9: A full write to a record whose protect bit is 1 has no effect. After the protect bit is set, only power-on reset clears it.
- R10: When both resets are asserted in the same cycle, the result is the power-on reset result.
- R11: rd_data uses the control word layout and returns the pointed-to channel number and that record's current fields. It reflects a newly accepted channel number from the clock edge that accepts the word. Bits 7:6 and 13:12 read as zero.
- R12: A full write with a generator value of 8 or more leaves the record's generator unchanged. The enable and protect fields are still written.
- R13: wr_ready is low in any cycle in which either reset is asserted. A word is accepted only when wr_valid and wr_ready are both high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| usr_rst | input | 1 | User reset, synchronous, active high |
| nv_wdt_en | input | 1 | Nonvolatile default for the watchdog enable |
| nv_wdt_aon | input | 1 | Nonvolatile default for the watchdog protect bit |
| wr_valid | input | 1 | Control word valid |
| wr_ready | output | 1 | Control word can be accepted |
| wr_full | input | 1 | 1: write the record; 0: move the read pointer only |
| wr_data | input | 16 | Control word |
| rd_data | output | 16 | Pointed-to channel number and record fields |

## Verification
The bench builds the block with its default parameters: 38 channels, a 6-bit channel field, a 4-bit generator field and 8 generators. With these values every channel number from 0 to 63 can be swept, so the reserved range is covered along with the implemented one, and every generator code from 0 to 15 is written, including the eight codes that must be refused. Each sweep is followed by a read-back of all 64 channel numbers. The sweeps run after power-on reset, after user resets with different protect and enable patterns, and after both resets in the same cycle, with both values of each nonvolatile input.

// File: rtl/clk_route_pkg.sv
package clk_route_pkg;
  typedef enum logic [1:0] {
    CH_PLAIN = 2'd0,
    CH_WDOG  = 2'd1,
    CH_RTC   = 2'd2
  } ch_kind_e;

  localparam int WORD_W   = 16;
  localparam int GEN_LSB  = 8;
  localparam int ENA_BIT  = 14;
  localparam int LOCK_BIT = 15;

  function automatic ch_kind_e kind_of(input int ch, input int wdog_ch, input int rtc_ch);
    if (ch == wdog_ch) return CH_WDOG;
    if (ch == rtc_ch)  return CH_RTC;
    return CH_PLAIN;
  endfunction
endpackage

// File: rtl/route_entry.sv
module route_entry
  import clk_route_pkg::*;
#(
  parameter ch_kind_e KIND    = CH_PLAIN,
  parameter int       GEN_W   = 4,
  parameter int       NUM_GEN = 8,
  parameter int       WDOG_GEN = 2
) (
  input  logic             clk,
  input  logic             por,
  input  logic             usr_rst,
  input  logic             nv_en,
  input  logic             nv_aon,
  input  logic             wr_hit,
  input  logic [GEN_W-1:0] wr_gen,
  input  logic             wr_ena,
  input  logic             wr_lock,
  output logic [GEN_W-1:0] gen_q,
  output logic             ena_q,
  output logic             lock_q
);
  localparam logic [GEN_W:0]   GEN_LIM = (GEN_W+1)'(NUM_GEN);
  localparam logic [GEN_W-1:0] DFLT_GEN = (KIND == CH_WDOG) ? GEN_W'(WDOG_GEN) : '0;

  logic gen_ok;
  logic usr_clear;
  assign gen_ok = ({1'b0, wr_gen} < GEN_LIM);

  generate
    if (KIND == CH_RTC) begin : g_rtc
      assign usr_clear = !lock_q && !ena_q;
    end else begin : g_other
      assign usr_clear = !lock_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (por) begin
      gen_q  <= DFLT_GEN;
      ena_q  <= (KIND == CH_WDOG) ? nv_en  : 1'b0;
      lock_q <= (KIND == CH_WDOG) ? nv_aon : 1'b0;
    end else if (usr_rst) begin
      if (usr_clear) begin
        gen_q <= DFLT_GEN;
        ena_q <= (KIND == CH_WDOG) ? nv_en : 1'b0;
      end
    end else if (wr_hit && !lock_q) begin
      if (gen_ok) gen_q <= wr_gen;
      ena_q  <= wr_ena;
      lock_q <= wr_lock;
    end
  end
endmodule

// File: rtl/route_rd_mux.sv
module route_rd_mux
  import clk_route_pkg::*;
#(
  parameter int NUM_CH = 38,
  parameter int IDX_W  = 6,
  parameter int GEN_W  = 4
) (
  input  logic [IDX_W-1:0]        sel,
  input  logic [NUM_CH*GEN_W-1:0] gen_flat,
  input  logic [NUM_CH-1:0]       ena_vec,
  input  logic [NUM_CH-1:0]       lock_vec,
  output logic [WORD_W-1:0]       word
);
  localparam logic [IDX_W:0] CH_LIM = (IDX_W+1)'(NUM_CH);

  always_comb begin
    word = '0;
    word[IDX_W-1:0] = sel;
    for (int i = 0; i < NUM_CH; i++) begin
      if ({1'b0, sel} == (IDX_W+1)'(i) && ({1'b0, sel} < CH_LIM)) begin
        word[GEN_LSB +: GEN_W] = gen_flat[i*GEN_W +: GEN_W];
        word[ENA_BIT]          = ena_vec[i];
        word[LOCK_BIT]         = lock_vec[i];
      end
    end
  end
endmodule

// File: rtl/clk_route_bank.sv
module clk_route_bank
  import clk_route_pkg::*;
#(
  parameter int NUM_CH   = 38,
  parameter int IDX_W    = 6,
  parameter int GEN_W    = 4,
  parameter int NUM_GEN  = 8,
  parameter int WDOG_CH  = 3,
  parameter int RTC_CH   = 4,
  parameter int WDOG_GEN = 2
) (
  input  logic        clk,
  input  logic        por,
  input  logic        usr_rst,
  input  logic        nv_wdt_en,
  input  logic        nv_wdt_aon,
  input  logic        wr_valid,
  output logic        wr_ready,
  input  logic        wr_full,
  input  logic [15:0] wr_data,
  output logic [15:0] rd_data
);
  logic                    fire;
  logic [IDX_W-1:0]        wr_idx;
  logic [IDX_W-1:0]        sel_q;
  logic [NUM_CH*GEN_W-1:0] gen_flat;
  logic [NUM_CH-1:0]       ena_vec;
  logic [NUM_CH-1:0]       lock_vec;

  assign wr_ready = !por && !usr_rst;
  assign fire     = wr_valid && wr_ready;
  assign wr_idx   = wr_data[IDX_W-1:0];

  always_ff @(posedge clk) begin
    if (por || usr_rst) sel_q <= '0;
    else if (fire)      sel_q <= wr_idx;
  end

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(i);
    logic hit;
    assign hit = fire && wr_full && (wr_idx == MY_IDX);
    route_entry #(
      .KIND(kind_of(i, WDOG_CH, RTC_CH)),
      .GEN_W(GEN_W),
      .NUM_GEN(NUM_GEN),
      .WDOG_GEN(WDOG_GEN)
    ) u_ent (
      .clk(clk),
      .por(por),
      .usr_rst(usr_rst),
      .nv_en(nv_wdt_en),
      .nv_aon(nv_wdt_aon),
      .wr_hit(hit),
      .wr_gen(wr_data[GEN_LSB +: GEN_W]),
      .wr_ena(wr_data[ENA_BIT]),
      .wr_lock(wr_data[LOCK_BIT]),
      .gen_q(gen_flat[i*GEN_W +: GEN_W]),
      .ena_q(ena_vec[i]),
      .lock_q(lock_vec[i])
    );
  end

  route_rd_mux #(
    .NUM_CH(NUM_CH),
    .IDX_W(IDX_W),
    .GEN_W(GEN_W)
  ) u_rd (
    .sel(sel_q),
    .gen_flat(gen_flat),
    .ena_vec(ena_vec),
    .lock_vec(lock_vec),
    .word(rd_data)
  );
endmodule

// File: rtl/clk_route_bank_chk.sv
module clk_route_bank_chk #(
  parameter int NUM_CH   = 38,
  parameter int IDX_W    = 6,
  parameter int GEN_W    = 4,
  parameter int NUM_GEN  = 8,
  parameter int WDOG_CH  = 3,
  parameter int WDOG_GEN = 2
) (
  input logic                    clk,
  input logic                    por,
  input logic                    usr_rst,
  input logic                    nv_wdt_en,
  input logic                    nv_wdt_aon,
  input logic [15:0]             rd_data,
  input logic [NUM_CH*GEN_W-1:0] gen_flat,
  input logic [NUM_CH-1:0]       ena_vec,
  input logic [NUM_CH-1:0]       lock_vec
);
  logic seen = 1'b0;
  always_ff @(posedge clk) seen <= seen | por;

  p_por_wdog_r3: assert property (@(posedge clk) disable iff (!seen)
    por |=> (gen_flat[WDOG_CH*GEN_W +: GEN_W] == GEN_W'(WDOG_GEN))
            && (ena_vec[WDOG_CH] == $past(nv_wdt_en))
            && (lock_vec[WDOG_CH] == $past(nv_wdt_aon)));

  p_usr_keeps_lock_r4: assert property (@(posedge clk) disable iff (!seen)
    (usr_rst && !por) |=> (lock_vec == $past(lock_vec)));

  p_rsvd_read_r1: assert property (@(posedge clk) disable iff (!seen)
    ({1'b0, rd_data[IDX_W-1:0]} >= (IDX_W+1)'(NUM_CH)) |-> (rd_data[15:8] == 8'h00));

  for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
    if (i != WDOG_CH) begin : g_nw
      p_por_clear_r2: assert property (@(posedge clk) disable iff (!seen)
        por |=> (gen_flat[i*GEN_W +: GEN_W] == '0) && !ena_vec[i] && !lock_vec[i]);
    end
    p_locked_frozen_r9: assert property (@(posedge clk) disable iff (!seen)
      (lock_vec[i] && !por) |=> lock_vec[i] && $stable(ena_vec[i])
                                && $stable(gen_flat[i*GEN_W +: GEN_W]));
    p_gen_range_r12: assert property (@(posedge clk) disable iff (!seen)
      ({1'b0, gen_flat[i*GEN_W +: GEN_W]} < (GEN_W+1)'(NUM_GEN)));
  end
endmodule

bind clk_route_bank clk_route_bank_chk #(
  .NUM_CH(NUM_CH), .IDX_W(IDX_W), .GEN_W(GEN_W), .NUM_GEN(NUM_GEN),
  .WDOG_CH(WDOG_CH), .WDOG_GEN(WDOG_GEN)
) u_chk (
  .clk(clk), .por(por), .usr_rst(usr_rst), .nv_wdt_en(nv_wdt_en),
  .nv_wdt_aon(nv_wdt_aon), .rd_data(rd_data), .gen_flat(gen_flat),
  .ena_vec(ena_vec), .lock_vec(lock_vec)
);

// File: tb/clk_route_bank_tb.sv
module clk_route_bank_tb;
  localparam int NCH = 38;
  localparam int WD  = 3;
  localparam int RT  = 4;

  logic clk = 1'b0;
  logic por = 1'b1, usr_rst = 1'b0, nv_en = 1'b0, nv_aon = 1'b0;
  logic wr_valid = 1'b0, wr_full = 1'b0;
  logic [15:0] wr_data = '0;
  logic wr_ready;
  logic [15:0] rd_data;

  int checks = 0, fails = 0;
  logic [3:0] m_gen [64];
  logic       m_en  [64];
  logic       m_lk  [64];

  always #2.5 clk = ~clk;

  clk_route_bank u_dut (
    .clk(clk), .por(por), .usr_rst(usr_rst), .nv_wdt_en(nv_en), .nv_wdt_aon(nv_aon),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_full(wr_full),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_word(input int ch);
    logic [15:0] w;
    w = 16'(ch);
    if (ch < NCH) begin
      w[11:8] = m_gen[ch];
      w[14]   = m_en[ch];
      w[15]   = m_lk[ch];
    end
    return w;
  endfunction

  task automatic model_por();
    for (int i = 0; i < 64; i++) begin
      m_gen[i] = 4'd0; m_en[i] = 1'b0; m_lk[i] = 1'b0;
    end
    m_gen[WD] = 4'd2; m_en[WD] = nv_en; m_lk[WD] = nv_aon;
  endtask

  task automatic model_usr();
    for (int i = 0; i < NCH; i++) begin
      if (i == WD) begin
        if (!m_lk[i]) begin m_gen[i] = 4'd2; m_en[i] = nv_en; end
      end else if (i == RT) begin
        if (!m_lk[i] && !m_en[i]) begin m_gen[i] = 4'd0; m_en[i] = 1'b0; end
      end else if (!m_lk[i]) begin
        m_gen[i] = 4'd0; m_en[i] = 1'b0;
      end
    end
  endtask

  task automatic do_reset(input logic p, input logic u);
    @(negedge clk);
    por = p; usr_rst = u;
    #1 chk("R13 ready low in reset", {15'd0, wr_ready}, 16'd0);
    @(negedge clk);
    por = 1'b0; usr_rst = 1'b0;
    if (p) model_por(); else model_usr();
  endtask

  task automatic wr(input int ch, input logic [3:0] g, input logic e, input logic l, input logic full);
    @(negedge clk);
    wr_valid = 1'b1; wr_full = full;
    wr_data = {l, e, 2'b00, g, 2'b00, 6'(ch)};
    @(negedge clk);
    wr_valid = 1'b0; wr_full = 1'b0;
    if (full && ch < NCH && !m_lk[ch]) begin
      if (g < 4'd8) m_gen[ch] = g;
      m_en[ch] = e; m_lk[ch] = l;
    end
  endtask

  task automatic read_all(input string req);
    for (int i = 0; i < 64; i++) begin
      wr(i, 4'hF, 1'b1, 1'b1, 1'b0);
      chk(req, rd_data, exp_word(i));
    end
  endtask

  initial begin
    #100000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    nv_en = 1'b1; nv_aon = 1'b0;
    repeat (2) @(negedge clk);
    por = 1'b0;
    model_por();
    chk("R11 pointer at reset", rd_data, exp_word(0));
    read_all("R2 R3 R1 after power-on");

    for (int i = 0; i < 64; i++)
      wr(i, 4'((i * 3) % 16), 1'(i % 2), (i % 5) == 0, 1'b1);
    read_all("R8 R12 R1 full-write sweep");

    for (int i = 0; i < 64; i++)
      wr(i, 4'((i + 1) % 8), 1'b1, 1'b0, 1'b1);
    read_all("R9 write to protected record");

    nv_en = 1'b0;
    do_reset(1'b0, 1'b1);
    read_all("R4 R5 R6 R7 user reset");

    wr(RT, 4'd5, 1'b1, 1'b0, 1'b1);
    do_reset(1'b0, 1'b1);
    read_all("R6 running clock record kept");
    wr(RT, 4'd3, 1'b0, 1'b0, 1'b1);
    do_reset(1'b0, 1'b1);
    wr(RT, 4'd0, 1'b0, 1'b0, 1'b0);
    chk("R6 stopped clock record cleared", rd_data, exp_word(RT));

    wr(WD, 4'd6, 1'b1, 1'b1, 1'b1);
    nv_en = 1'b1;
    do_reset(1'b0, 1'b1);
    wr(WD, 4'd0, 1'b0, 1'b0, 1'b0);
    chk("R7 protected watchdog kept", rd_data, exp_word(WD));

    nv_en = 1'b0; nv_aon = 1'b1;
    do_reset(1'b1, 1'b1);
    read_all("R10 R3 both resets");

    for (int g = 0; g < 16; g++) begin
      wr(10, 4'(g), 1'(g % 2), 1'b0, 1'b1);
      chk("R12 R11 generator code sweep", rd_data, exp_word(10));
    end
    wr(10, 4'd0, 1'b0, 1'b0, 1'b1);
    do_reset(1'b0, 1'b1);
    wr(WD, 4'd1, 1'b1, 1'b0, 1'b1);
    chk("R7 R9 protected watchdog write", rd_data, exp_word(WD));

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule